// File: doc/BRIEF.md
# Sixty-Four-Way Cache Tag and Line-State Controller

This block holds the tag, valid and dirty state of a 16 KB cache with 64 ways, 8 sets and 32-byte (8-word) lines. A 32-bit address is presented on a valid/ready request port. One cycle after acceptance, the response reports hit or miss, the hit way, the way to evict on a miss, whether that victim needs writing back (and which half-lines), and whether a write must be sent to memory right now. Write hits in write-back mode mark the half-line dirty. In write-through mode they leave the line clean and go to memory.

Victim choice always takes the lowest-numbered invalid way first. When the set is full, a configuration pin picks between a per-set round-robin pointer and a free-running 6-bit pseudo-random generator. A separate refill-complete port installs a tag into a named way once the line data has arrived. That install also advances the set's round-robin pointer. A single-cycle invalidate-all input wipes every valid and dirty bit.

Back-pressure rules: `req_ready` is high whenever no response is waiting or the waiting response is being taken in the same cycle (`rsp_ready` high). A request is accepted on a rising edge with `req_valid` and `req_ready` both high. A response stays valid and unchanged until a cycle with `rsp_ready` high. The refill port and the configuration pins have no handshake.

Top module: `cache_tag_ctrl`

## Requirements
- R1: The address splits into byte offset [4:0], set index [7:5] and tag [31:8]. A request accepted on edge N gives `rsp_valid` after edge N. `rsp_hit` is 1 exactly when a valid way of that set holds that tag, and `rsp_hit_way` then names it.
- R2: While `rsp_valid` is high and `rsp_ready` low, `req_ready` is low and every response field holds its value. The stalled request is accepted on the edge where the response is taken.
- R3: A refill (`fill_valid`) writes the tag of `fill_addr` into way `fill_way` of its set, sets valid and clears both dirty bits. A lookup accepted on the same edge still sees the state from before the refill.
- R4: On a miss, the victim is the lowest-numbered invalid way of the set whenever one exists, whatever replacement mode is selected.
- R5: With `cfg_repl_rr`=1 and a full set, the victim is that set's 6-bit pointer. The pointer starts at 0, rises by one on every refill into its own set, wraps from 63 to 0, and is independent of other sets.
- R6: With `cfg_repl_rr`=0 and a full set, the victim comes from a free-running nonzero 6-bit generator. It is therefore never way 0, and it changes from one lookup to the next.
- R7: With `cfg_write_back`=1, a write hit sets dirty bit 0 when address bit 4 is 0 (words 0–3) or dirty bit 1 when it is 1 (words 4–7), and reports `rsp_mem_write`=0.
- R8: With `cfg_write_back`=0, a write hit reports `rsp_mem_write`=1 and leaves the dirty bits unchanged. A write miss reports `rsp_mem_write`=1 in either mode, and a read never does.
- R9: On a miss, `rsp_wb_needed` is 1 exactly when the victim is valid with at least one dirty bit, and `rsp_wb_halves` equals the victim's dirty bits (bit 0 = words 0–3). A hit reports 0 on both.
- R10: `inv_all` clears all valid and dirty bits on one edge, overriding a refill or dirty mark on that same edge. A lookup accepted on the following edge misses.
- R11: When a refill and a write-hit dirty mark target the same line on the same edge, the refill wins and the line ends clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_repl_rr | input | 1 | 1 = round-robin victim, 0 = pseudo-random |
| cfg_write_back | input | 1 | 1 = write-back, 0 = write-through |
| inv_all | input | 1 | Clear all valid and dirty bits |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be accepted |
| req_addr | input | 32 | Lookup byte address |
| req_write | input | 1 | Lookup is a write |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_hit | output | 1 | Lookup hit |
| rsp_hit_way | output | 6 | Way that hit (0 on miss) |
| rsp_victim_way | output | 6 | Way to replace on miss |
| rsp_wb_needed | output | 1 | Victim must be written back |
| rsp_wb_halves | output | 2 | Victim dirty halves to write back |
| rsp_mem_write | output | 1 | Write must go to memory now |
| fill_valid | input | 1 | Refill complete |
| fill_addr | input | 32 | Address of the refilled line |
| fill_way | input | 6 | Way receiving the refill |

## Verification
Two pairs of functions can land on one clock edge: a refill completing alongside a lookup of the same set, and a refill alongside a write-hit dirty mark on the same line. The bench drives both requests on the same negative edge. For the first pair, it judges that the lookup reports the pre-refill miss and that the next lookup hits. For the second, it evicts that line later and expects no write-back, with a lone write hit on the same line as a control that does produce one. Invalidate-all is likewise issued together with a refill, and the refilled line must come back invalid.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;
  localparam int unsigned ADDR_W_DEF     = 32;
  localparam int unsigned WAYS_DEF       = 64;
  localparam int unsigned SETS_DEF       = 8;
  localparam int unsigned LINE_BYTES_DEF = 32;
  localparam int unsigned HALVES         = 2;

  typedef enum logic {
    REPL_RANDOM = 1'b0,
    REPL_ROUND  = 1'b1
  } repl_mode_e;
endpackage

// File: rtl/cache_tag_lfsr.sv
module cache_tag_lfsr #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] value
);
  logic [W-1:0] q;
  logic         fb;

  // taps for a maximal-length 6-bit sequence (x^6 + x^5 + 1)
  assign fb = q[W-1] ^ q[W-2];

  always_ff @(posedge clk) begin
    if (!rst_n) q <= W'(1);
    else        q <= {q[W-2:0], fb};
  end

  assign value = q;
endmodule

// File: rtl/cache_tag_prienc.sv
module cache_tag_prienc #(
  parameter int unsigned N = 64,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          found
);
  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx   = IW'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int unsigned SETS  = 8,
  parameter int unsigned WAYS  = 64,
  parameter int unsigned TAG_W = 24,
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         inv_all,
  input  logic [IDX_W-1:0]             rd_set,
  output logic [WAYS-1:0]              rd_valid,
  output logic [WAYS-1:0][1:0]         rd_dirty,
  output logic [WAYS-1:0][TAG_W-1:0]   rd_tag,
  output logic [WAY_W-1:0]             rd_ptr,
  input  logic                         fill_en,
  input  logic [IDX_W-1:0]             fill_set,
  input  logic [WAY_W-1:0]             fill_way,
  input  logic [TAG_W-1:0]             fill_tag,
  input  logic                         mark_en,
  input  logic [IDX_W-1:0]             mark_set,
  input  logic [WAY_W-1:0]             mark_way,
  input  logic                         mark_half
);
  logic [WAYS-1:0]            valid_q [SETS];
  logic [WAYS-1:0][1:0]       dirty_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
  logic [WAY_W-1:0]           ptr_q   [SETS];

  // line state: invalidate beats everything, refill beats dirty mark
  always_ff @(posedge clk) begin
    if (!rst_n || inv_all) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else begin
      if (mark_en) dirty_q[mark_set][mark_way][mark_half] <= 1'b1;
      if (fill_en) begin
        valid_q[fill_set][fill_way] <= 1'b1;
        dirty_q[fill_set][fill_way] <= 2'b00;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) tag_q[s] <= '0;
    end else if (fill_en) begin
      tag_q[fill_set][fill_way] <= fill_tag;
    end
  end

  // per-set round-robin pointers, advanced by each allocation
  generate
    for (genvar s = 0; s < SETS; s++) begin : g_ptr
      always_ff @(posedge clk) begin
        if (!rst_n) ptr_q[s] <= '0;
        else if (fill_en && fill_set == IDX_W'(s)) ptr_q[s] <= ptr_q[s] + 1'b1;
      end
    end
  endgenerate

  assign rd_valid = valid_q[rd_set];
  assign rd_dirty = dirty_q[rd_set];
  assign rd_tag   = tag_q[rd_set];
  assign rd_ptr   = ptr_q[rd_set];
endmodule

// File: rtl/cache_tag_victim.sv
module cache_tag_victim #(
  parameter int unsigned WAYS = 64,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  set_valid,
  input  logic [WAY_W-1:0] rr_ptr,
  input  logic [WAY_W-1:0] rnd,
  input  logic             use_rr,
  output logic [WAY_W-1:0] victim
);
  logic [WAY_W-1:0] free_way;
  logic             has_free;
  logic [WAY_W-1:0] policy_way;

  cache_tag_prienc #(.N(WAYS)) u_free (
    .vec   (~set_valid),
    .idx   (free_way),
    .found (has_free)
  );

  assign policy_way = (use_rr == cache_tag_pkg::REPL_ROUND) ? rr_ptr : rnd;
  assign victim     = has_free ? free_way : policy_way;
endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl #(
  parameter int unsigned ADDR_W     = cache_tag_pkg::ADDR_W_DEF,
  parameter int unsigned WAYS       = cache_tag_pkg::WAYS_DEF,
  parameter int unsigned SETS       = cache_tag_pkg::SETS_DEF,
  parameter int unsigned LINE_BYTES = cache_tag_pkg::LINE_BYTES_DEF,
  localparam int unsigned OFF_W = $clog2(LINE_BYTES),
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned TAG_W = ADDR_W - OFF_W - IDX_W,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_repl_rr,
  input  logic              cfg_write_back,
  input  logic              inv_all,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_hit_way,
  output logic [WAY_W-1:0]  rsp_victim_way,
  output logic              rsp_wb_needed,
  output logic [1:0]        rsp_wb_halves,
  output logic              rsp_mem_write,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [WAY_W-1:0]  fill_way
);
  // request address fields
  logic [IDX_W-1:0] lk_set;
  logic [TAG_W-1:0] lk_tag;
  logic             lk_half;

  assign lk_set  = req_addr[OFF_W +: IDX_W];
  assign lk_tag  = req_addr[ADDR_W-1 -: TAG_W];
  assign lk_half = req_addr[OFF_W-1];

  logic [WAYS-1:0]            set_valid;
  logic [WAYS-1:0][1:0]       set_dirty;
  logic [WAYS-1:0][TAG_W-1:0] set_tag;
  logic [WAY_W-1:0]           set_ptr;
  logic [WAY_W-1:0]           rnd;
  logic                       accept;
  logic                       mark_en;

  cache_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .inv_all   (inv_all),
    .rd_set    (lk_set),
    .rd_valid  (set_valid),
    .rd_dirty  (set_dirty),
    .rd_tag    (set_tag),
    .rd_ptr    (set_ptr),
    .fill_en   (fill_valid),
    .fill_set  (fill_addr[OFF_W +: IDX_W]),
    .fill_way  (fill_way),
    .fill_tag  (fill_addr[ADDR_W-1 -: TAG_W]),
    .mark_en   (mark_en),
    .mark_set  (lk_set),
    .mark_way  (hit_way),
    .mark_half (lk_half)
  );

  cache_tag_lfsr #(.W(WAY_W)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .value (rnd)
  );

  // tag compare across all ways of the selected set
  logic [WAYS-1:0] hit_vec;
  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hit_vec[w] = set_valid[w] && (set_tag[w] == lk_tag);
    end
  endgenerate

  logic [WAY_W-1:0] hit_way;
  logic             hit;

  cache_tag_prienc #(.N(WAYS)) u_hit (
    .vec   (hit_vec),
    .idx   (hit_way),
    .found (hit)
  );

  logic [WAY_W-1:0] victim;

  cache_tag_victim #(.WAYS(WAYS)) u_victim (
    .set_valid (set_valid),
    .rr_ptr    (set_ptr),
    .rnd       (rnd),
    .use_rr    (cfg_repl_rr),
    .victim    (victim)
  );

  // write policy and write-back decision
  logic [1:0] victim_dirty;
  logic       wb_need;
  logic       mem_wr;

  assign victim_dirty = set_valid[victim] ? set_dirty[victim] : 2'b00;
  assign wb_need      = !hit && (victim_dirty != 2'b00);
  assign mem_wr       = req_write && (!cfg_write_back || !hit);

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign mark_en   = accept && req_write && hit && cfg_write_back;

  // response register, held while the consumer stalls
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_hit        <= 1'b0;
      rsp_hit_way    <= '0;
      rsp_victim_way <= '0;
      rsp_wb_needed  <= 1'b0;
      rsp_wb_halves  <= 2'b00;
      rsp_mem_write  <= 1'b0;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit        <= hit;
        rsp_hit_way    <= hit ? hit_way : '0;
        rsp_victim_way <= victim;
        rsp_wb_needed  <= wb_need;
        rsp_wb_halves  <= wb_need ? victim_dirty : 2'b00;
        rsp_mem_write  <= mem_wr;
      end
    end
  end
endmodule

// File: rtl/cache_tag_chk.sv
module cache_tag_chk #(
  parameter int unsigned WAY_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             inv_all,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_hit,
  input logic [WAY_W-1:0] rsp_hit_way,
  input logic [WAY_W-1:0] rsp_victim_way,
  input logic             rsp_wb_needed,
  input logic [1:0]       rsp_wb_halves,
  input logic             rsp_mem_write
);
  logic wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) wr_q <= 1'b0;
    else if (req_valid && req_ready) wr_q <= req_write;
  end

  p_resp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  p_stall_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  p_stall_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_hit) && $stable(rsp_hit_way)
      && $stable(rsp_victim_way) && $stable(rsp_wb_halves) && $stable(rsp_mem_write));

  p_read_no_mem_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !wr_q |-> !rsp_mem_write);

  p_wmiss_mem_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && wr_q && !rsp_hit |-> rsp_mem_write);

  p_hit_no_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hit |-> !rsp_wb_needed && rsp_wb_halves == 2'b00);

  p_wb_has_half_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_wb_needed |-> rsp_wb_halves != 2'b00);

  p_inv_then_miss_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(inv_all) && req_valid && req_ready |=> !rsp_hit);
endmodule

bind cache_tag_ctrl cache_tag_chk #(.WAY_W(WAY_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .inv_all        (inv_all),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .req_write      (req_write),
  .rsp_valid      (rsp_valid),
  .rsp_ready      (rsp_ready),
  .rsp_hit        (rsp_hit),
  .rsp_hit_way    (rsp_hit_way),
  .rsp_victim_way (rsp_victim_way),
  .rsp_wb_needed  (rsp_wb_needed),
  .rsp_wb_halves  (rsp_wb_halves),
  .rsp_mem_write  (rsp_mem_write)
);

// File: tb/sim_cache_tag_ctrl.sv
`timescale 1ns/1ps
module sim_cache_tag_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_repl_rr = 1'b1;
  logic        cfg_write_back = 1'b1;
  logic        inv_all = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_hit;
  logic [5:0]  rsp_hit_way;
  logic [5:0]  rsp_victim_way;
  logic        rsp_wb_needed;
  logic [1:0]  rsp_wb_halves;
  logic        rsp_mem_write;
  logic        fill_valid = 1'b0;
  logic [31:0] fill_addr = '0;
  logic [5:0]  fill_way = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  cache_tag_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_repl_rr(cfg_repl_rr), .cfg_write_back(cfg_write_back),
    .inv_all(inv_all), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_hit_way(rsp_hit_way), .rsp_victim_way(rsp_victim_way), .rsp_wb_needed(rsp_wb_needed),
    .rsp_wb_halves(rsp_wb_halves), .rsp_mem_write(rsp_mem_write), .fill_valid(fill_valid),
    .fill_addr(fill_addr), .fill_way(fill_way)
  );

  function automatic logic [31:0] mk(input logic [23:0] tag, input logic [2:0] set, input logic half);
    return {tag, set, half, 4'h0};
  endfunction

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // one lookup; results sampled on the negedge after acceptance
  task automatic lookup(input logic [31:0] a, input logic wr);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic fill(input logic [31:0] a, input logic [5:0] way);
    @(negedge clk);
    fill_valid = 1'b1; fill_addr = a; fill_way = way;
    @(posedge clk);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic fill_all(input logic [2:0] set, input logic [23:0] base);
    for (int w = 0; w < 64; w++) fill(mk(base + 24'(w), set, 1'b0), 6'(w));
  endtask

  task automatic t_reset;
    check("R2 reset req_ready", 32'(req_ready), 1);
    check("R1 reset rsp_valid", 32'(rsp_valid), 0);
    lookup(mk(24'h0, 3'd0, 1'b0), 1'b0);
    check("R1 rsp_valid after accept", 32'(rsp_valid), 1);
    check("R1 empty lookup misses", 32'(rsp_hit), 0);
    check("R4 empty set victim way0", 32'(rsp_victim_way), 0);
  endtask

  task automatic t_basic;
    fill(mk(24'hABCDEF, 3'd2, 1'b0), 6'd0);
    lookup(mk(24'hABCDEF, 3'd2, 1'b1), 1'b0);
    check("R1 hit after fill", 32'(rsp_hit), 1);
    check("R1 hit way", 32'(rsp_hit_way), 0);
    lookup(mk(24'h123456, 3'd2, 1'b0), 1'b0);
    check("R4 next free way", 32'(rsp_victim_way), 1);
    lookup(mk(24'hABCDEF, 3'd1, 1'b0), 1'b0);
    check("R1 set index separates", 32'(rsp_hit), 0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    req_valid = 1'b1; req_addr = mk(24'h000BEE, 3'd2, 1'b0); req_write = 1'b0;
    fill_valid = 1'b1; fill_addr = mk(24'h000BEE, 3'd2, 1'b0); fill_way = 6'd1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; fill_valid = 1'b0;
    check("R3 same-edge lookup sees old state", 32'(rsp_hit), 0);
    lookup(mk(24'h000BEE, 3'd2, 1'b0), 1'b0);
    check("R3 later lookup hits", 32'(rsp_hit), 1);
    check("R3 refilled way", 32'(rsp_hit_way), 1);
  endtask

  task automatic t_writeback;
    cfg_repl_rr = 1'b1; cfg_write_back = 1'b1;
    fill_all(3'd3, 24'h000100);
    lookup(mk(24'h000100, 3'd3, 1'b1), 1'b1);
    check("R7 write hit", 32'(rsp_hit), 1);
    check("R7 wb write no memory", 32'(rsp_mem_write), 0);
    lookup(mk(24'h000999, 3'd3, 1'b0), 1'b0);
    check("R5 wrapped pointer victim", 32'(rsp_victim_way), 0);
    check("R9 dirty victim wb", 32'(rsp_wb_needed), 1);
    check("R9 upper half only", 32'(rsp_wb_halves), 2);
    lookup(mk(24'h000100, 3'd3, 1'b0), 1'b1);
    lookup(mk(24'h000999, 3'd3, 1'b0), 1'b0);
    check("R7 both halves dirty", 32'(rsp_wb_halves), 3);
    lookup(mk(24'h000100, 3'd3, 1'b0), 1'b0);
    check("R9 hit reports no wb", 32'({rsp_wb_needed, rsp_wb_halves}), 0);
    fill(mk(24'h000300, 3'd3, 1'b0), 6'd0);
    lookup(mk(24'h000999, 3'd3, 1'b0), 1'b0);
    check("R5 pointer advanced", 32'(rsp_victim_way), 1);
    check("R9 clean victim", 32'(rsp_wb_needed), 0);
    lookup(mk(24'h000300, 3'd3, 1'b0), 1'b0);
    check("R3 replaced line hits", 32'({rsp_hit, rsp_hit_way}), 32'h40);
  endtask

  task automatic t_writethrough;
    cfg_write_back = 1'b0;
    lookup(mk(24'h000101, 3'd3, 1'b1), 1'b1);
    check("R8 wt write hit", 32'({rsp_hit, rsp_hit_way}), 32'h41);
    check("R8 wt write to memory", 32'(rsp_mem_write), 1);
    lookup(mk(24'h000999, 3'd3, 1'b0), 1'b0);
    check("R8 wt leaves line clean", 32'({rsp_victim_way, rsp_wb_needed}), 32'h2);
    lookup(mk(24'h000777, 3'd3, 1'b0), 1'b1);
    check("R8 write miss to memory", 32'({rsp_hit, rsp_mem_write}), 1);
    lookup(mk(24'h000102, 3'd3, 1'b0), 1'b0);
    check("R8 read no memory", 32'({rsp_hit, rsp_mem_write}), 2);
    cfg_write_back = 1'b1;
  endtask

  task automatic t_random;
    logic [5:0] first;
    int distinct;
    cfg_repl_rr = 1'b0;
    distinct = 0;
    first = '0;
    for (int i = 0; i < 8; i++) begin
      repeat (i + 1) @(negedge clk);
      lookup(mk(24'h000999, 3'd3, 1'b0), 1'b0);
      check("R6 random victim nonzero", 32'(rsp_victim_way != 6'd0), 1);
      if (i == 0) first = rsp_victim_way;
      else if (rsp_victim_way != first) distinct++;
    end
    check("R6 random victim varies", 32'(distinct > 0), 1);
    lookup(mk(24'h000999, 3'd4, 1'b0), 1'b0);
    check("R4 free way beats random", 32'(rsp_victim_way), 0);
    cfg_repl_rr = 1'b1;
  endtask

  task automatic t_rr_sets;
    fill_all(3'd5, 24'h000500);
    lookup(mk(24'h000999, 3'd5, 1'b0), 1'b0);
    check("R5 wrap 63 to 0", 32'(rsp_victim_way), 0);
    lookup(mk(24'h000999, 3'd3, 1'b0), 1'b0);
    check("R5 other set pointer", 32'(rsp_victim_way), 1);
  endtask

  task automatic t_fill_vs_mark;
    cfg_write_back = 1'b1;
    @(negedge clk);
    req_valid = 1'b1; req_addr = mk(24'h000501, 3'd5, 1'b1); req_write = 1'b1;
    fill_valid = 1'b1; fill_addr = mk(24'h000501, 3'd5, 1'b0); fill_way = 6'd1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; fill_valid = 1'b0;
    check("R11 write hit reported", 32'(rsp_hit), 1);
    lookup(mk(24'h000999, 3'd5, 1'b0), 1'b0);
    check("R11 refill wins victim", 32'(rsp_victim_way), 1);
    check("R11 line left clean", 32'(rsp_wb_needed), 0);
    lookup(mk(24'h000501, 3'd5, 1'b0), 1'b1);
    lookup(mk(24'h000999, 3'd5, 1'b0), 1'b0);
    check("R7 lower half marked", 32'({rsp_wb_needed, rsp_wb_halves}), 5);
  endtask

  task automatic t_handshake;
    logic [6:0] held;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_addr = mk(24'h000502, 3'd5, 1'b0); req_write = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R2 stall drops ready", 32'({rsp_valid, req_ready}), 2);
    held = {rsp_hit, rsp_hit_way};
    check("R1 first response", 32'(held), 32'h42);
    req_addr = mk(24'h000503, 3'd5, 1'b0);
    @(negedge clk);
    check("R2 response held", 32'({rsp_hit, rsp_hit_way}), 32'(held));
    check("R2 still stalled", 32'(req_ready), 0);
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 pending request accepted", 32'({rsp_valid, rsp_hit, rsp_hit_way}), 32'hC3);
  endtask

  task automatic t_invalidate;
    @(negedge clk);
    inv_all = 1'b1;
    fill_valid = 1'b1; fill_addr = mk(24'h000600, 3'd6, 1'b0); fill_way = 6'd2;
    @(posedge clk);
    @(negedge clk);
    inv_all = 1'b0; fill_valid = 1'b0;
    lookup(mk(24'h000600, 3'd6, 1'b0), 1'b0);
    check("R10 refill overridden", 32'({rsp_hit, rsp_victim_way}), 0);
    lookup(mk(24'h000501, 3'd5, 1'b0), 1'b0);
    check("R10 dirty cleared", 32'({rsp_hit, rsp_victim_way, rsp_wb_needed}), 0);
    lookup(mk(24'hABCDEF, 3'd2, 1'b0), 1'b0);
    check("R10 all sets cleared", 32'(rsp_hit), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_same_cycle();
    t_writeback();
    t_writethrough();
    t_random();
    t_rr_sets();
    t_fill_vs_mark();
    t_handshake();
    t_invalidate();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule